// File: doc/BRIEF.md
# Retriggerable Overcurrent Fault Hold

This block turns short current-limit events into a steady, active-low fault indication. Each time the chopping logic resets its PWM latch because the load current reached its peak, it sends a one-cycle pulse into this block. The fault output goes low on the clock edge that takes in the pulse. It stays low while further pulses keep arriving inside a hold window. A countdown window restarts from zero on every pulse, so the flag does not flicker during sustained current limiting. The flag clears only after a full window passes with no pulse.

When the bridge is disabled or sleeping, the block clears the flag and idles the window. Reset does the same. An optional busy status reports that the hold window is running. A parameter can tie this status to zero. The window length is a parameter counted in clock cycles. Its default is 3000 cycles, which is 300 µs at 10 MHz.

Top module: `ocp_fault_hold`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after any edge that sampled it high, `fault_n_o` is 1 and `busy_o` is 0. This holds even if a hold window was running.
- R2: A clock edge that samples `trip_i`=1 with `bridge_on_i`=1 makes `fault_n_o` 0 immediately after that edge.
- R3: After a single pulse, `fault_n_o` stays 0 for exactly HOLD_CYCLES clock cycles. It returns to 1 on the HOLD_CYCLES-th edge after the edge that took the pulse.
- R4: Every accepted pulse restarts the window from zero, so the release falls HOLD_CYCLES edges after the last pulse.
- R5: A pulse sampled on the edge where the window would expire wins. `fault_n_o` stays 0 and a full new window of HOLD_CYCLES cycles starts.
- R6: An edge that samples `bridge_on_i`=0 makes `fault_n_o` 1 and idles the window. A pulse sampled on such an edge is ignored, so the output stays 1 afterwards.
- R7: With BUSY_EN=1, `busy_o` equals the inverse of `fault_n_o` in every cycle. With BUSY_EN=0, `busy_o` is constantly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bridge_on_i | input | 1 | 1 = bridge enabled and awake; 0 = disabled or asleep |
| trip_i | input | 1 | One-cycle pulse per peak-current latch reset |
| fault_n_o | output | 1 | Fault flag, active low |
| busy_o | output | 1 | Hold window running (0 when BUSY_EN=0) |

## Verification
The bench builds the block with HOLD_CYCLES=8. With this value, a full window, a restart partway through a window, and a pulse landing exactly on the expiry edge all fit in a few dozen cycles, and every cycle's expected level can be listed. A second instance with BUSY_EN=0 runs on the same stimulus. It shows that the status variant stays at zero while the fault behaviour is unchanged.

// File: rtl/ofh_pkg.sv
package ofh_pkg;
   typedef enum logic {
      OFH_IDLE = 1'b0,
      OFH_HOLD = 1'b1
   } ofh_state_e;
endpackage

// File: rtl/ofh_qualify.sv
// Folds reset and bridge state into one kill term and gates trip pulses.
module ofh_qualify (
   input  logic rst_i,
   input  logic bridge_on_i,
   input  logic trip_i,
   output logic kill_o,
   output logic trip_ok_o
);
   always_comb begin
      kill_o    = rst_i | ~bridge_on_i;
      trip_ok_o = trip_i & bridge_on_i & ~rst_i;
   end
endmodule

// File: rtl/ofh_timer.sv
// Restartable hold window: counts quiet cycles, drops hold at the limit.
module ofh_timer #(
   parameter int HOLD_CYCLES = 3000
) (
   input  logic clk_i,
   input  logic kill_i,
   input  logic trip_i,
   output logic hold_o
);
   import ofh_pkg::*;

   localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

   ofh_state_e     state_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (kill_i) begin
         state_q <= OFH_IDLE;
         cnt_q   <= '0;
      end else if (trip_i) begin
         // a pulse always wins, even on the expiry edge
         state_q <= OFH_HOLD;
         cnt_q   <= '0;
      end else if (state_q == OFH_HOLD) begin
         if (cnt_q == LAST) begin
            state_q <= OFH_IDLE;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign hold_o = (state_q == OFH_HOLD);
endmodule

// File: rtl/ocp_fault_hold.sv
module ocp_fault_hold #(
   parameter int HOLD_CYCLES = 3000,
   parameter bit BUSY_EN     = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic bridge_on_i,
   input  logic trip_i,
   output logic fault_n_o,
   output logic busy_o
);
   generate
      if (HOLD_CYCLES < 2) begin : g_bad_hold
         $error("ocp_fault_hold: HOLD_CYCLES must be at least 2");
      end
   endgenerate

   logic kill;
   logic trip_ok;
   logic hold;

   ofh_qualify u_qual (
      .rst_i       (rst_i),
      .bridge_on_i (bridge_on_i),
      .trip_i      (trip_i),
      .kill_o      (kill),
      .trip_ok_o   (trip_ok)
   );

   ofh_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
      .clk_i  (clk_i),
      .kill_i (kill),
      .trip_i (trip_ok),
      .hold_o (hold)
   );

   assign fault_n_o = ~hold;

   generate
      if (BUSY_EN) begin : g_busy
         assign busy_o = hold;
      end else begin : g_no_busy
         assign busy_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/ocp_fault_hold_chk.sv
module ocp_fault_hold_chk #(
   parameter int HOLD_CYCLES = 3000,
   parameter bit BUSY_EN     = 1'b1
) (
   input logic clk_i,
   input logic rst_i,
   input logic bridge_on_i,
   input logic trip_i,
   input logic fault_n_o,
   input logic busy_o
);
   localparam int QW = $clog2(HOLD_CYCLES + 1) + 1;
   localparam logic [QW-1:0] QMAX = QW'(HOLD_CYCLES);

   // cycles the flag has been low since the last accepted pulse
   logic [QW-1:0] quiet_q;
   always_ff @(posedge clk_i) begin
      if (rst_i || !bridge_on_i)     quiet_q <= QMAX;
      else if (trip_i)               quiet_q <= '0;
      else if (!fault_n_o && quiet_q < QMAX) quiet_q <= quiet_q + 1'b1;
   end

   assert_reset_idle_R1: assert property (@(posedge clk_i)
      $past(rst_i) |-> (fault_n_o && !busy_o));

   assert_trip_sets_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      (bridge_on_i && trip_i) |=> !fault_n_o);

   assert_hold_bound_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      !fault_n_o |-> (quiet_q < QMAX));

   assert_release_time_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(fault_n_o) |-> (quiet_q == QMAX));

   assert_off_clears_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      !bridge_on_i |=> fault_n_o);

   assert_busy_track_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      busy_o == (BUSY_EN ? !fault_n_o : 1'b0));
endmodule

bind ocp_fault_hold ocp_fault_hold_chk #(
   .HOLD_CYCLES (HOLD_CYCLES),
   .BUSY_EN     (BUSY_EN)
) u_chk (
   .clk_i       (clk_i),
   .rst_i       (rst_i),
   .bridge_on_i (bridge_on_i),
   .trip_i      (trip_i),
   .fault_n_o   (fault_n_o),
   .busy_o      (busy_o)
);

// File: tb/ocp_fault_hold_bench.sv
`timescale 1ns/1ps
module ocp_fault_hold_bench;
   localparam int H = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic on  = 1'b0;
   logic trip = 1'b0;
   logic fn, busy, fn2, busy2;
   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   ocp_fault_hold #(.HOLD_CYCLES(H), .BUSY_EN(1'b1)) u_ocp_fault_hold (
      .clk_i(clk), .rst_i(rst), .bridge_on_i(on), .trip_i(trip),
      .fault_n_o(fn), .busy_o(busy));

   ocp_fault_hold #(.HOLD_CYCLES(H), .BUSY_EN(1'b0)) u_ocp_fault_hold_nobusy (
      .clk_i(clk), .rst_i(rst), .bridge_on_i(on), .trip_i(trip),
      .fault_n_o(fn2), .busy_o(busy2));

   // {bridge_on, trip, expected fault_n after the edge}
   localparam logic [2:0] VEC [48] = '{
      3'b101,                                          // 0  idle
      3'b110,                                          // 1  R2 pulse sets fault
      3'b100,3'b100,3'b100,3'b100,3'b100,3'b100,3'b100,// 2-8  R3 held
      3'b101,                                          // 9  R3 release after H
      3'b110,                                          // 10 R4
      3'b100,3'b100,3'b100,                            // 11-13
      3'b110,                                          // 14 R4 restart
      3'b100,3'b100,3'b100,3'b100,3'b100,3'b100,3'b100,// 15-21
      3'b101,                                          // 22 R4 release
      3'b110,                                          // 23 R5 start
      3'b100,3'b100,3'b100,3'b100,3'b100,3'b100,3'b100,// 24-30
      3'b110,                                          // 31 R5 pulse on expiry edge
      3'b100,3'b100,3'b100,3'b100,3'b100,3'b100,3'b100,// 32-38 R5 full new window
      3'b101,                                          // 39
      3'b110,                                          // 40 R6
      3'b100,                                          // 41
      3'b001,                                          // 42 R6 off clears
      3'b011,                                          // 43 R6 pulse ignored
      3'b101,                                          // 44 R6 still idle
      3'b110,                                          // 45
      3'b011,                                          // 46 R6 off beats pulse
      3'b101                                           // 47
   };

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(input logic von, input logic vtrip);
      @(negedge clk);
      on = von; trip = vtrip;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset fault_n", fn, 1'b1);
      check("R1 reset busy", busy, 1'b0);
      @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < 48; i++) begin
         step(VEC[i][2], VEC[i][1]);
         check($sformatf("table row %0d fault_n", i), fn, VEC[i][0]);
         check($sformatf("R7 row %0d busy", i), busy, ~VEC[i][0]);
         check($sformatf("R7 row %0d variant fault_n", i), fn2, VEC[i][0]);
         check($sformatf("R7 row %0d variant busy", i), busy2, 1'b0);
      end

      // R1: reset in the middle of a hold window
      step(1'b1, 1'b1);
      check("R2 directed set", fn, 1'b0);
      step(1'b1, 1'b0);
      @(negedge clk);
      rst = 1'b1; trip = 1'b0;
      @(posedge clk);
      #1;
      check("R1 mid-hold reset fault_n", fn, 1'b1);
      check("R1 mid-hold reset busy", busy, 1'b0);
      @(negedge clk);
      rst = 1'b0;
      step(1'b1, 1'b0);
      check("R1 idle after reset", fn, 1'b1);

      // R5: repeated pulses exactly every H cycles never release
      step(1'b1, 1'b1);
      for (int k = 0; k < 3; k++) begin
         for (int j = 0; j < H - 1; j++) step(1'b1, 1'b0);
         check("R5 before expiry edge", fn, 1'b0);
         step(1'b1, 1'b1);
         check("R5 pulse on expiry edge", fn, 1'b0);
      end
      for (int j = 0; j < H; j++) step(1'b1, 1'b0);
      check("R3 final release", fn, 1'b1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule